// File: doc/BRIEF.md
# Convolutional Decoder Node Sync Controller

This block decides which of the two possible symbol pairings feeds a rate-1/2 Viterbi decoder, and keeps watching that choice while data flows. It does not count errors itself. An external comparator re-encodes the decoder's output and counts disagreements with the hard-decided input symbols. The controller asks that comparator for a count window, and the comparator answers with a count and a one-cycle done strobe.

Acquisition starts once symbol timing is locked. The controller measures the two pairings one after the other. It keeps the better one only if that pairing is clearly better and also good enough in absolute terms. Otherwise it resets the decoder and starts again. During tracking it keeps a halving running average of the error counts. It compares each new count with a threshold taken from that average plus a margin, optionally capped by a curve driven by the SNR estimate, or overridden by a manual value. After too many failures in a row it drops lock.

Top module: `nodesync_ctrl`

## Requirements
- R1: While `rst_n` is low, and on release, `in_sync`, `phase_sel`, `win_req` and `dec_reset` are 0, `dec_thr` is 255 and `win_blocks` is 1.
- R2: A first window request (phase 0) is issued only in the cycle after `timing_lock` was seen high in the idle state. Outside tracking, `dec_thr` is 255 and `win_blocks` is 1.
- R3: Acquisition issues one single-cycle `win_req` with `phase_sel`=0. It then waits for `err_done` and stores S0. Next it issues one `win_req` with `phase_sel`=1 and waits for `err_done` to store S1. An `err_done` outside a waiting state has no effect.
- R4: One cycle after S1 is stored, acquisition succeeds if |S0−S1| ≥ `alpha0` and min(S0,S1) < `alpha1`. On success `phase_sel` is 1 when S1 < S0 and 0 otherwise (a tie keeps 0). It stays fixed for the whole tracking period.
- R5: A failed acquisition raises `dec_reset` for exactly one cycle and then returns to idle. A new attempt starts again only if `timing_lock` is high.
- R6: On success `in_sync` rises, the failure count is cleared and the average XA is set to K·min(S0,S1), with K = 2^`k_sel`. Each tracking window request carries `win_blocks` = K.
- R7: A tracking count SS with SS < TS sets XA to (XA+SS)/2. XA keeps one fractional bit, and the integer part is used in TS.
- R8: A tracking count SS ≥ TS raises the failure count by one, and a passing count clears it. When the count would exceed `loss_limit`, `dec_reset` pulses for one cycle, `in_sync` falls and acquisition restarts.
- R9: In tracking, `dec_thr` = TS = floor(XA) + `delta_s`, saturated to 4095. When `snr_en` is 1, TS is the smaller of that value and T_SNR. `dec_thr` follows the configuration inputs in the same cycle.
- R10: With `snr_q` in units of 1/64 dB, T_SNR = 730 − floor(50·`snr_q`/64) for `snr_q` ≤ 480, and 355 above that.
- R11: When `man_en` is 1 during tracking, TS and `dec_thr` equal `man_thr`, ignoring the average, the margin and the SNR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| timing_lock | input | 1 | Symbol timing recovery is locked |
| err_done | input | 1 | One-cycle strobe: `err_cnt` is valid |
| err_cnt | input | 12 | Disagreement count of the finished window |
| snr_q | input | 10 | Es/N0 estimate, 1/64 dB per LSB |
| snr_en | input | 1 | Cap the tracking threshold by the SNR curve |
| alpha0 | input | 8 | Minimum count separation for acquisition |
| alpha1 | input | 12 | Bound the best acquisition count must stay under |
| delta_s | input | 8 | Margin added to the running average |
| loss_limit | input | 4 | Allowed consecutive tracking failures |
| k_sel | input | 2 | Tracking window multiplier, K = 2^k_sel |
| man_thr | input | 12 | Manual tracking threshold |
| man_en | input | 1 | Use `man_thr` as the tracking threshold |
| phase_sel | output | 1 | Symbol pairing applied to the decoder |
| dec_reset | output | 1 | One-cycle decoder reset pulse |
| in_sync | output | 1 | Tracking with a selected pairing |
| dec_thr | output | 12 | Error threshold handed to the decoder |
| win_req | output | 1 | One-cycle request for a new count window |
| win_blocks | output | 4 | Window length in base windows (1 or K) |

## Verification
Every output except `dec_thr` is a Moore output of the controller state. It changes one edge after the strobe, lock or decision that causes it. The decision lands one cycle after S1 is taken, and the drop pulse lands on the edge after a losing count. `dec_thr` is combinational from the average register and the configuration inputs. It moves in the same cycle as a configuration change and one edge after a tracking count updates XA. The bench drives inputs and samples outputs on the falling edge. It advances a behavioural model on each rising edge and compares all six outputs every cycle. Hand-computed values are checked at stall points where the controller waits for a count that has not yet been given.

// File: rtl/nodesync_pkg.sv
package nodesync_pkg;

   typedef enum logic [3:0] {
      NS_IDLE,
      NS_ACQ0_REQ,
      NS_ACQ0_WAIT,
      NS_ACQ1_REQ,
      NS_ACQ1_WAIT,
      NS_JUDGE,
      NS_TRK_REQ,
      NS_TRK_WAIT,
      NS_DROP
   } ns_state_t;

   localparam int ACQ_THRESHOLD = 255;
   localparam int SNR_KNEE      = 480;
   localparam int SNR_THR_HIGH  = 730;
   localparam int SNR_THR_LOW   = 355;
   localparam int SNR_THR_W     = 11;

endpackage

// File: rtl/nodesync_snr_thr.sv
module nodesync_snr_thr
   import nodesync_pkg::*;
#(
   parameter int CW = 12,
   parameter int SW = 10
) (
   input  logic [SW-1:0] snr_q,
   output logic [CW-1:0] thr
);
   localparam int RW = SNR_THR_W;

   logic [SW+5:0] scaled;
   logic [SW-1:0] drop;
   logic [RW-1:0] raw;

   // 50 = 32 + 16 + 2, then divide by 64
   assign scaled = ({6'd0, snr_q} << 5) + ({6'd0, snr_q} << 4) + ({6'd0, snr_q} << 1);
   assign drop   = SW'(scaled >> 6);

   always_comb begin
      if (32'(snr_q) <= SNR_KNEE) raw = RW'(SNR_THR_HIGH) - RW'(drop);
      else                        raw = RW'(SNR_THR_LOW);
   end

   generate
      if (CW >= RW) begin : g_wide
         assign thr = CW'(raw);
      end else begin : g_clip
         assign thr = (raw > RW'({CW{1'b1}})) ? '1 : CW'(raw);
      end
      if (SW < 1) begin : g_bad_sw
         $error("nodesync_snr_thr: SW must be at least 1");
      end
   endgenerate

endmodule

// File: rtl/nodesync_acq_judge.sv
module nodesync_acq_judge #(
   parameter int CW = 12,
   parameter int AW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cap0,
   input  logic          cap1,
   input  logic [CW-1:0] cnt,
   input  logic [AW-1:0] alpha0,
   input  logic [CW-1:0] alpha1,
   output logic          pass,
   output logic          best_one,
   output logic [CW-1:0] smin
);
   logic [CW-1:0] s0_q, s1_q;
   logic [CW-1:0] sep;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s0_q <= '0;
         s1_q <= '0;
      end else begin
         if (cap0) s0_q <= cnt;
         if (cap1) s1_q <= cnt;
      end
   end

   assign sep      = (s0_q >= s1_q) ? (s0_q - s1_q) : (s1_q - s0_q);
   assign best_one = (s1_q < s0_q);
   assign smin     = best_one ? s1_q : s0_q;
   assign pass     = (sep >= CW'(alpha0)) && (smin < alpha1);

   generate
      if (AW > CW) begin : g_bad_aw
         $error("nodesync_acq_judge: AW must not exceed CW");
      end
   endgenerate

endmodule

// File: rtl/nodesync_track_dp.sv
module nodesync_track_dp #(
   parameter int CW    = 12,
   parameter int DW    = 8,
   parameter int LW    = 4,
   parameter int KSELW = 2,
   parameter int FRACB = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             upd,
   input  logic [CW-1:0]    cnt,
   input  logic [CW-1:0]    smin,
   input  logic [KSELW-1:0] k_sel,
   input  logic [DW-1:0]    delta_s,
   input  logic [LW-1:0]    loss_limit,
   input  logic [CW-1:0]    snr_thr,
   input  logic             snr_en,
   input  logic [CW-1:0]    man_thr,
   input  logic             man_en,
   output logic [CW-1:0]    ts,
   output logic             good,
   output logic             lost
);
   localparam int KSH = (2 ** KSELW) - 1;
   localparam int XIW = CW + KSH;
   localparam int XW  = XIW + FRACB;

   logic [XW-1:0]  xa_q;
   logic [LW:0]    ul_q;
   logic [XIW-1:0] xa_init;
   logic [XW:0]    xa_sum;
   logic [XW-1:0]  xa_next;
   logic [XIW-1:0] xa_int;
   logic [XIW:0]   auto_thr;
   logic [CW-1:0]  auto_sat;
   logic [CW-1:0]  capped;
   logic [LW:0]    ul_inc;

   assign xa_init  = XIW'(smin) << k_sel;
   assign xa_sum   = {1'b0, xa_q} + ((XW + 1)'(cnt) << FRACB);
   assign xa_next  = XW'(xa_sum >> 1);
   assign xa_int   = XIW'(xa_q >> FRACB);
   assign auto_thr = {1'b0, xa_int} + (XIW + 1)'(delta_s);
   assign auto_sat = (auto_thr > (XIW + 1)'({CW{1'b1}})) ? '1 : CW'(auto_thr);
   assign capped   = (snr_en && (snr_thr < auto_sat)) ? snr_thr : auto_sat;
   assign ts       = man_en ? man_thr : capped;
   assign good     = (cnt < ts);
   assign ul_inc   = ul_q + (LW + 1)'(1);
   assign lost     = !good && (ul_inc > (LW + 1)'(loss_limit));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         xa_q <= '0;
         ul_q <= '0;
      end else if (load) begin
         xa_q <= XW'(xa_init) << FRACB;
         ul_q <= '0;
      end else if (upd) begin
         if (good) begin
            xa_q <= xa_next;
            ul_q <= '0;
         end else begin
            ul_q <= ul_inc;
         end
      end
   end

   generate
      if (DW > CW) begin : g_bad_dw
         $error("nodesync_track_dp: DW must not exceed CW");
      end
      if (FRACB < 0 || FRACB > 4) begin : g_bad_frac
         $error("nodesync_track_dp: FRACB out of range");
      end
   endgenerate

endmodule

// File: rtl/nodesync_ctrl.sv
module nodesync_ctrl
   import nodesync_pkg::*;
#(
   parameter int CW    = 12,
   parameter int SW    = 10,
   parameter int AW    = 8,
   parameter int DW    = 8,
   parameter int LW    = 4,
   parameter int KSELW = 2,
   parameter int FRACB = 1,
   localparam int BLKW = 2 ** KSELW
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             timing_lock,
   input  logic             err_done,
   input  logic [CW-1:0]    err_cnt,
   input  logic [SW-1:0]    snr_q,
   input  logic             snr_en,
   input  logic [AW-1:0]    alpha0,
   input  logic [CW-1:0]    alpha1,
   input  logic [DW-1:0]    delta_s,
   input  logic [LW-1:0]    loss_limit,
   input  logic [KSELW-1:0] k_sel,
   input  logic [CW-1:0]    man_thr,
   input  logic             man_en,
   output logic             phase_sel,
   output logic             dec_reset,
   output logic             in_sync,
   output logic [CW-1:0]    dec_thr,
   output logic             win_req,
   output logic [BLKW-1:0]  win_blocks
);
   ns_state_t     state_q, state_d;
   logic          sel_q;
   logic          cap0, cap1, load, upd;
   logic          pass, best_one, good, lost;
   logic [CW-1:0] smin, ts, snr_thr;

   assign cap0 = (state_q == NS_ACQ0_WAIT) && err_done;
   assign cap1 = (state_q == NS_ACQ1_WAIT) && err_done;
   assign load = (state_q == NS_JUDGE) && pass;
   assign upd  = (state_q == NS_TRK_WAIT) && err_done;

   nodesync_acq_judge #(.CW(CW), .AW(AW)) u_judge (
      .clk      (clk),
      .rst_n    (rst_n),
      .cap0     (cap0),
      .cap1     (cap1),
      .cnt      (err_cnt),
      .alpha0   (alpha0),
      .alpha1   (alpha1),
      .pass     (pass),
      .best_one (best_one),
      .smin     (smin)
   );

   nodesync_snr_thr #(.CW(CW), .SW(SW)) u_snr (
      .snr_q (snr_q),
      .thr   (snr_thr)
   );

   nodesync_track_dp #(.CW(CW), .DW(DW), .LW(LW), .KSELW(KSELW), .FRACB(FRACB)) u_track (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (load),
      .upd        (upd),
      .cnt        (err_cnt),
      .smin       (smin),
      .k_sel      (k_sel),
      .delta_s    (delta_s),
      .loss_limit (loss_limit),
      .snr_thr    (snr_thr),
      .snr_en     (snr_en),
      .man_thr    (man_thr),
      .man_en     (man_en),
      .ts         (ts),
      .good       (good),
      .lost       (lost)
   );

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         NS_IDLE:      if (timing_lock) state_d = NS_ACQ0_REQ;
         NS_ACQ0_REQ:  state_d = NS_ACQ0_WAIT;
         NS_ACQ0_WAIT: if (err_done) state_d = NS_ACQ1_REQ;
         NS_ACQ1_REQ:  state_d = NS_ACQ1_WAIT;
         NS_ACQ1_WAIT: if (err_done) state_d = NS_JUDGE;
         NS_JUDGE:     state_d = pass ? NS_TRK_REQ : NS_DROP;
         NS_TRK_REQ:   state_d = NS_TRK_WAIT;
         NS_TRK_WAIT:  if (err_done) state_d = lost ? NS_DROP : NS_TRK_REQ;
         NS_DROP:      state_d = NS_IDLE;
         default:      state_d = NS_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= NS_IDLE;
         sel_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         if (load) sel_q <= best_one;
      end
   end

   assign in_sync    = (state_q == NS_TRK_REQ) || (state_q == NS_TRK_WAIT);
   assign win_req    = (state_q == NS_ACQ0_REQ) || (state_q == NS_ACQ1_REQ) ||
                       (state_q == NS_TRK_REQ);
   assign dec_reset  = (state_q == NS_DROP);
   assign phase_sel  = in_sync ? sel_q :
                       ((state_q == NS_ACQ1_REQ) || (state_q == NS_ACQ1_WAIT));
   assign dec_thr    = in_sync ? ts : CW'(ACQ_THRESHOLD);
   assign win_blocks = in_sync ? (BLKW'(1) << k_sel) : BLKW'(1);

   generate
      if (CW < 9) begin : g_bad_cw
         $error("nodesync_ctrl: CW must hold the acquisition threshold");
      end
      if (KSELW < 1 || KSELW > 3) begin : g_bad_ksel
         $error("nodesync_ctrl: KSELW out of range");
      end
   endgenerate

endmodule

// File: rtl/nodesync_ctrl_chk.sv
module nodesync_ctrl_chk #(
   parameter int CW = 12
) (
   input logic          clk,
   input logic          rst_n,
   input logic          timing_lock,
   input logic          man_en,
   input logic [CW-1:0] man_thr,
   input logic          phase_sel,
   input logic          dec_reset,
   input logic          in_sync,
   input logic [CW-1:0] dec_thr,
   input logic          win_req
);
   // R2
   start_after_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (win_req && !in_sync && !phase_sel) |-> $past(timing_lock));

   // R3
   req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      win_req |=> !win_req);

   // R4
   phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_sync && $past(in_sync)) |-> $stable(phase_sel));

   // R5
   drop_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dec_reset |=> (!dec_reset && !in_sync));

   // R8
   sync_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(in_sync) |-> dec_reset);

   // R11
   manual_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_sync && man_en) |-> (dec_thr == man_thr));

endmodule

bind nodesync_ctrl nodesync_ctrl_chk #(.CW(CW)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .timing_lock (timing_lock),
   .man_en      (man_en),
   .man_thr     (man_thr),
   .phase_sel   (phase_sel),
   .dec_reset   (dec_reset),
   .in_sync     (in_sync),
   .dec_thr     (dec_thr),
   .win_req     (win_req)
);

// File: tb/nodesync_ctrl_test.sv
module nodesync_ctrl_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        timing_lock = 1'b0;
   logic        err_done = 1'b0;
   logic [11:0] err_cnt = '0;
   logic [9:0]  snr_q = '0;
   logic        snr_en = 1'b0;
   logic [7:0]  alpha0 = 8'd5;
   logic [11:0] alpha1 = 12'd100;
   logic [7:0]  delta_s = 8'd20;
   logic [3:0]  loss_limit = 4'd2;
   logic [1:0]  k_sel = 2'd0;
   logic [11:0] man_thr = '0;
   logic        man_en = 1'b0;
   logic        phase_sel, dec_reset, in_sync, win_req;
   logic [11:0] dec_thr;
   logic [3:0]  win_blocks;

   int checks = 0;
   int errors = 0;
   int drops = 0;
   int reqs = 0;
   int cd = -1;
   int cq[$];

   // behavioural reference state
   int m_st = 0;
   int m_sel = 0;
   int m_s0 = 0;
   int m_s1 = 0;
   int m_xa2 = 0;
   int m_ul = 0;

   always #10 clk = ~clk;

   nodesync_ctrl uut (
      .clk(clk), .rst_n(rst_n), .timing_lock(timing_lock), .err_done(err_done),
      .err_cnt(err_cnt), .snr_q(snr_q), .snr_en(snr_en), .alpha0(alpha0),
      .alpha1(alpha1), .delta_s(delta_s), .loss_limit(loss_limit), .k_sel(k_sel),
      .man_thr(man_thr), .man_en(man_en), .phase_sel(phase_sel),
      .dec_reset(dec_reset), .in_sync(in_sync), .dec_thr(dec_thr),
      .win_req(win_req), .win_blocks(win_blocks)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic int snr_curve(input int s);
      if (s <= 480) return 730 - (50 * s) / 64;
      return 355;
   endfunction

   function automatic int exp_ts();
      int t;
      if (man_en) return int'(man_thr);
      t = m_xa2 / 2 + int'(delta_s);
      if (t > 4095) t = 4095;
      if (snr_en && snr_curve(int'(snr_q)) < t) t = snr_curve(int'(snr_q));
      return t;
   endfunction

   task automatic model_update();
      int mn, sep;
      if (!rst_n) begin
         m_st = 0; m_sel = 0; m_s0 = 0; m_s1 = 0; m_xa2 = 0; m_ul = 0;
         return;
      end
      case (m_st)
         0: if (timing_lock) m_st = 1;
         1: m_st = 2;
         2: if (err_done) begin m_s0 = int'(err_cnt); m_st = 3; end
         3: m_st = 4;
         4: if (err_done) begin m_s1 = int'(err_cnt); m_st = 5; end
         5: begin
            sep = (m_s0 > m_s1) ? m_s0 - m_s1 : m_s1 - m_s0;
            mn  = (m_s1 < m_s0) ? m_s1 : m_s0;
            if (sep >= int'(alpha0) && mn < int'(alpha1)) begin
               m_sel = (m_s1 < m_s0) ? 1 : 0;
               m_xa2 = (mn * (1 << k_sel)) * 2;
               m_ul = 0;
               m_st = 6;
            end else m_st = 8;
         end
         6: m_st = 7;
         7: if (err_done) begin
            if (int'(err_cnt) < exp_ts()) begin
               m_ul = 0;
               m_xa2 = (m_xa2 + 2 * int'(err_cnt)) / 2;
               m_st = 6;
            end else begin
               m_ul++;
               m_st = (m_ul > int'(loss_limit)) ? 8 : 6;
            end
         end
         default: m_st = 0;
      endcase
   endtask

   task automatic compare();
      int tr, ei, er, ep;
      tr = (m_st == 6 || m_st == 7) ? 1 : 0;
      er = (m_st == 1 || m_st == 3 || m_st == 6) ? 1 : 0;
      ep = tr ? m_sel : ((m_st == 3 || m_st == 4) ? 1 : 0);
      ei = tr ? exp_ts() : 255;
      chk("R8 in_sync", int'(in_sync), tr);
      chk("R3 win_req", int'(win_req), er);
      chk("R4 phase_sel", int'(phase_sel), ep);
      chk("R5 dec_reset", int'(dec_reset), (m_st == 8) ? 1 : 0);
      chk("R9 dec_thr", int'(dec_thr), ei);
      chk("R6 win_blocks", int'(win_blocks), tr ? (1 << k_sel) : 1);
   endtask

   task automatic emulate_counter();
      err_done = 1'b0;
      if (cd > 0) cd--;
      if (cd == 0 && cq.size() > 0) begin
         err_done = 1'b1;
         err_cnt = 12'(cq.pop_front());
         cd = -1;
      end
      if (win_req) cd = 2;
   endtask

   task automatic step();
      @(posedge clk);
      model_update();
      @(negedge clk);
      emulate_counter();
      #1;
      compare();
      if (dec_reset) drops++;
      if (win_req) reqs++;
   endtask

   task automatic run(input int n);
      for (int i = 0; i < n; i++) step();
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      run(3);
      // R1: outputs under reset
      chk("R1 in_sync", int'(in_sync), 0);
      chk("R1 dec_thr", int'(dec_thr), 255);
      chk("R1 win_req", int'(win_req), 0);
      chk("R1 win_blocks", int'(win_blocks), 1);
      rst_n = 1'b1;
      run(10);
      // R2: nothing starts without timing lock
      chk("R2 no request before lock", reqs, 0);

      // R4 two failing attempts (separation, then absolute bound), then phase 1 wins
      cq.push_back(50); cq.push_back(52);
      cq.push_back(200); cq.push_back(300);
      cq.push_back(30); cq.push_back(10);
      timing_lock = 1'b1;
      run(60);
      chk("R5 drop pulses after two failures", drops, 2);
      chk("R4 in_sync after success", int'(in_sync), 1);
      chk("R4 phase 1 selected", int'(phase_sel), 1);
      chk("R6 threshold K*Smin+margin", int'(dec_thr), 30);

      // R7 running average with half bit
      cq.push_back(5);
      run(12);
      chk("R7 average after 5", int'(dec_thr), 27);
      cq.push_back(6);
      run(12);
      chk("R7 average after 6", int'(dec_thr), 26);

      // R8 consecutive failures, interrupted by a pass
      cq.push_back(40); cq.push_back(40); cq.push_back(3);
      cq.push_back(40); cq.push_back(40);
      run(50);
      chk("R8 still in sync at limit", int'(in_sync), 1);
      chk("R8 threshold after pass", int'(dec_thr), 24);
      cq.push_back(40);
      run(15);
      chk("R8 lock lost", int'(in_sync), 0);
      chk("R8 third drop", drops, 3);
      chk("R2 acquisition threshold", int'(dec_thr), 255);

      // R4 tie keeps phase 0; R6 K=8
      k_sel = 2'd3; alpha0 = 8'd0; alpha1 = 12'd4095; delta_s = 8'd255;
      cq.push_back(100); cq.push_back(100);
      run(30);
      chk("R4 tie selects phase 0", int'(phase_sel), 0);
      chk("R6 window blocks K", int'(win_blocks), 8);
      chk("R6 threshold with K=8", int'(dec_thr), 1055);

      // R10 SNR curve in 1/64 dB
      snr_en = 1'b1;
      snr_q = 10'd0;    run(1); chk("R10 snr 0", int'(dec_thr), 730);
      snr_q = 10'd64;   run(1); chk("R10 snr 1dB", int'(dec_thr), 680);
      snr_q = 10'd100;  run(1); chk("R10 snr 100", int'(dec_thr), 652);
      snr_q = 10'd480;  run(1); chk("R10 snr knee", int'(dec_thr), 355);
      snr_q = 10'd481;  run(1); chk("R10 snr above knee", int'(dec_thr), 355);
      snr_q = 10'd1023; run(1); chk("R10 snr max", int'(dec_thr), 355);
      snr_en = 1'b0;
      run(1);
      chk("R9 cap removed", int'(dec_thr), 1055);

      // R11 manual threshold
      man_en = 1'b1; man_thr = 12'd2048;
      run(1);
      chk("R11 manual threshold", int'(dec_thr), 2048);
      cq.push_back(2047);
      run(12);
      chk("R11 count below manual passes", int'(in_sync), 1);
      cq.push_back(2048);
      run(12);
      man_en = 1'b0;
      run(1);
      chk("R7 average after manual pass", int'(dec_thr), 1678);

      // R9 saturation
      cq.push_back(4000); cq.push_back(4000);
      cq.push_back(600); cq.push_back(900);
      run(60);
      chk("R9 saturated threshold", int'(dec_thr), 4095);
      cq.push_back(4094);
      run(12);
      chk("R9 still saturated", int'(dec_thr), 4095);
      cq.push_back(4095);
      run(12);
      chk("R8 count at threshold keeps sync", int'(in_sync), 1);

      timing_lock = 1'b0;
      run(5);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule